// File: doc/BRIEF.md
# Cache Miss Service Sequencer

This block runs the bus side of a processor stall. The pipeline raises `start` for one cycle with a description of the access that missed or bypassed the caches. The block then moves the needed words over a word-wide request/acknowledge bus and raises `done` so the pipeline can leave its stall. The cache arrays and tag compare stay outside. The block reads victim words through a line-buffer read port and writes refill words through a line-buffer write port.

There are five kinds of access:

- **Data miss with a dirty victim:** the victim line is written back first, then the new line is refilled.
- **Data miss with a clean victim:** the new line is refilled.
- **Instruction miss:** a longer line is refilled and the word the fetch stage asked for is forwarded.
- **Uncached data access:** one or two word transfers; a doubleword is split into two words.
- **Uncached instruction fetch:** a single word is read.

Data-line words are stored under an index permutation (XOR with a parameter) that accounts for byte order. Each kind of access ends with its own settle delay before `done`.

Top module: `miss_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `done`, `bus_req` and `lb_wr_en` are low. A reset in the middle of an access abandons it.
- R2: Once `bus_req` is high it stays high, with `bus_addr` and `bus_we` unchanged, until a clock edge sees `bus_ack` high. Each acknowledge completes exactly one word transfer, and addresses are word aligned.
- R3: An uncached data read aligns the address down to 8 bytes for a doubleword and to 4 bytes otherwise. A doubleword reads the aligned address first and address+4 second, and `load_data` returns {first, second}. A single word returns in `load_data[31:0]` with the upper half zero.
- R4: Uncached writes (`op_write` with `op_cached` and `op_instr` low) work as follows. A doubleword sends `st_wdata[63:32]` with `st_wmask[7:4]` first, then `st_wdata[31:0]` with `st_wmask[3:0]`. A single word sends `st_wdata[31:0]` with `st_wmask[3:0]`. Bit i of `bus_be` enables byte lane i.
- R5: A cached data miss with `victim_dirty` high first issues four writes to `victim_addr` aligned down to 16 bytes, at offsets 0, 4, 8 and 12. The write at offset 4i carries the line-buffer word at read index i XOR WORD_XOR, and `bus_be` is 4'hF. All four writes come before any refill read.
- R6: A cached data miss reads four words starting at `req_addr` aligned down to 16 bytes. The word from offset 4i is written to line-buffer index i XOR WORD_XOR. A clean victim causes no writes.
- R7: A cached instruction miss reads eight words starting at `req_addr` aligned down to 32 bytes and writes them to line-buffer indices 0 to 7 in order. `fetch_word` returns the word whose index equals `req_addr[4:2]`.
- R8: An uncached instruction fetch reads one word at `req_addr` aligned down to 4 bytes and returns it on `fetch_word`.
- R9: `done` is a one-cycle pulse. It rises D+1 clock edges after the edge that accepts the final acknowledge. D is UNC_DELAY for uncached accesses, DC_DELAY for cached data misses and IC_DELAY for cached instruction misses.
- R10: `busy` rises on the edge that takes `start` and falls on the edge that raises `done`. A `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin servicing the described access (sampled only when idle) |
| op_instr | input | 1 | Access is an instruction fetch |
| op_cached | input | 1 | Access targets cacheable space (line refill) |
| op_write | input | 1 | Uncached data store |
| op_dword | input | 1 | Uncached data access is a doubleword |
| victim_dirty | input | 1 | Victim data line must be written back |
| req_addr | input | AW | Physical address of the access |
| victim_addr | input | AW | Address of the victim line |
| st_wdata | input | 2*WW | Store data for uncached writes |
| st_wmask | input | 2*WW/8 | Per-byte store enables for uncached writes |
| bus_req | output | 1 | Word transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | AW | Word address of the transfer |
| bus_wdata | output | WW | Write data |
| bus_be | output | WW/8 | Byte enables |
| bus_ack | input | 1 | Transfer accepted this edge |
| bus_rdata | input | WW | Read data, valid with bus_ack |
| lb_rd_idx | output | log2(ILINE_WORDS) | Line-buffer read index for victim words |
| lb_rd_data | input | WW | Victim word at lb_rd_idx (combinational) |
| lb_wr_en | output | 1 | Refill word write strobe |
| lb_wr_idx | output | log2(ILINE_WORDS) | Refill word index |
| lb_wr_data | output | WW | Refill word |
| fetch_word | output | WW | Instruction word delivered to fetch |
| load_data | output | 2*WW | Result of an uncached data read |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:

- **Dirty victim followed by refill:** a sequencer that refilled first, or skipped the index XOR on victim reads, would put wrong data or wrong order on the bus.
- **Instruction line whose wanted word is the last one:** this exposes a fetch-word capture that stops early or decodes the wrong address bits.
- **Doubleword reads and writes at unaligned addresses:** this catches a swapped half order, a wrong alignment mask, or byte masks attached to the wrong word.
- **Variable acknowledge latency:** every transfer count and the exact cycle of `done` are compared against the settle delay of each kind of access, so a skipped beat, a double-counted acknowledge or a mixed-up delay shows up as a cycle or count mismatch.
- **`start` pulsed during an access, and reset in mid-access:** these prove no second access launches and that the block recovers cleanly.

// File: rtl/miss_seq_pkg.sv
package miss_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WBACK,
    PH_FILL,
    PH_UNC,
    PH_SETTLE
  } phase_e;

  typedef struct packed {
    logic instr;
    logic cached;
    logic write;
    logic dword;
  } op_t;

endpackage

// File: rtl/miss_seq_addr.sv
module miss_seq_addr
  import miss_seq_pkg::*;
#(
  parameter int AW          = 32,
  parameter int WW          = 32,
  parameter int DLINE_WORDS = 4,
  parameter int ILINE_WORDS = 8
) (
  input  phase_e                           phase,
  input  logic                             instr,
  input  logic                             dword,
  input  logic [AW-1:0]                    req_addr,
  input  logic [AW-1:0]                    victim_addr,
  input  logic [$clog2(ILINE_WORDS)-1:0]   beat,
  output logic [AW-1:0]                    addr
);
  localparam int BEW = WW / 8;
  localparam int WBO = $clog2(BEW);
  localparam int DBO = WBO + 1;
  localparam int DLO = $clog2(DLINE_WORDS * BEW);
  localparam int ILO = $clog2(ILINE_WORDS * BEW);

  logic [AW-1:0] base;

  always_comb begin
    unique case (phase)
      PH_WBACK: base = {victim_addr[AW-1:DLO], {DLO{1'b0}}};
      PH_FILL:  base = instr ? {req_addr[AW-1:ILO], {ILO{1'b0}}}
                             : {req_addr[AW-1:DLO], {DLO{1'b0}}};
      PH_UNC:   base = dword ? {req_addr[AW-1:DBO], {DBO{1'b0}}}
                             : {req_addr[AW-1:WBO], {WBO{1'b0}}};
      default:  base = req_addr;
    endcase
    addr = base + (AW'(beat) << WBO);
  end

endmodule

// File: rtl/miss_seq_timer.sv
module miss_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt == CW'(1)) |=> zero);

endmodule

// File: rtl/miss_seq.sv
module miss_seq
  import miss_seq_pkg::*;
#(
  parameter int AW          = 32,
  parameter int WW          = 32,
  parameter int DLINE_WORDS = 4,
  parameter int ILINE_WORDS = 8,
  parameter int WORD_XOR    = 1,
  parameter int UNC_DELAY   = 2,
  parameter int DC_DELAY    = 3,
  parameter int IC_DELAY    = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic                           op_instr,
  input  logic                           op_cached,
  input  logic                           op_write,
  input  logic                           op_dword,
  input  logic                           victim_dirty,
  input  logic [AW-1:0]                  req_addr,
  input  logic [AW-1:0]                  victim_addr,
  input  logic [2*WW-1:0]                st_wdata,
  input  logic [2*WW/8-1:0]              st_wmask,
  output logic                           bus_req,
  output logic                           bus_we,
  output logic [AW-1:0]                  bus_addr,
  output logic [WW-1:0]                  bus_wdata,
  output logic [WW/8-1:0]                bus_be,
  input  logic                           bus_ack,
  input  logic [WW-1:0]                  bus_rdata,
  output logic [$clog2(ILINE_WORDS)-1:0] lb_rd_idx,
  input  logic [WW-1:0]                  lb_rd_data,
  output logic                           lb_wr_en,
  output logic [$clog2(ILINE_WORDS)-1:0] lb_wr_idx,
  output logic [WW-1:0]                  lb_wr_data,
  output logic [WW-1:0]                  fetch_word,
  output logic [2*WW-1:0]                load_data,
  output logic                           busy,
  output logic                           done
);
  localparam int BEW  = WW / 8;
  localparam int IW   = $clog2(ILINE_WORDS);
  localparam int WBO  = $clog2(BEW);
  localparam int IBO  = $clog2(ILINE_WORDS * BEW);
  localparam int MAXD = (UNC_DELAY > DC_DELAY) ?
                        ((UNC_DELAY > IC_DELAY) ? UNC_DELAY : IC_DELAY) :
                        ((DC_DELAY > IC_DELAY) ? DC_DELAY : IC_DELAY);
  localparam int CW   = (MAXD < 1) ? 1 : $clog2(MAXD + 1);
  localparam logic [IW-1:0] XORV = IW'(WORD_XOR);

  phase_e          state;
  op_t             op_r, in_op, cur_op;
  logic [AW-1:0]   raddr_r, vaddr_r, cur_raddr, cur_vaddr, nx_addr;
  logic [WW-1:0]   unc_wdata_r, lo_wdata_r;
  logic [BEW-1:0]  lo_be_r;
  logic [IW-1:0]   beat, nx_beat;
  phase_e          nx_phase, first_ph;
  logic            last_beat, beat_done;
  logic            tmr_load, tmr_tick, tmr_zero;
  logic [CW-1:0]   tmr_val;

  assign beat_done = bus_req && bus_ack;
  assign bus_wdata = (state == PH_WBACK) ? lb_rd_data : unc_wdata_r;

  always_comb begin
    in_op.instr  = op_instr;
    in_op.cached = op_cached;
    in_op.write  = op_write & ~op_instr & ~op_cached;
    in_op.dword  = op_dword & ~op_instr & ~op_cached;
    cur_op    = (state == PH_IDLE) ? in_op    : op_r;
    cur_raddr = (state == PH_IDLE) ? req_addr : raddr_r;
    cur_vaddr = (state == PH_IDLE) ? victim_addr : vaddr_r;
    if (!op_cached)                    first_ph = PH_UNC;
    else if (!op_instr && victim_dirty) first_ph = PH_WBACK;
    else                               first_ph = PH_FILL;
    unique case (state)
      PH_WBACK: last_beat = (beat == IW'(DLINE_WORDS - 1));
      PH_FILL:  last_beat = (beat == (op_r.instr ? IW'(ILINE_WORDS - 1)
                                                 : IW'(DLINE_WORDS - 1)));
      PH_UNC:   last_beat = (beat == (op_r.dword ? IW'(1) : IW'(0)));
      default:  last_beat = 1'b0;
    endcase
    if (state == PH_IDLE) begin
      nx_phase = first_ph;
      nx_beat  = '0;
    end else if (state == PH_WBACK && last_beat) begin
      nx_phase = PH_FILL;
      nx_beat  = '0;
    end else begin
      nx_phase = state;
      nx_beat  = beat + 1'b1;
    end
    if (!op_r.cached)    tmr_val = CW'(UNC_DELAY);
    else if (op_r.instr) tmr_val = CW'(IC_DELAY);
    else                 tmr_val = CW'(DC_DELAY);
    tmr_load = beat_done && last_beat && (state == PH_FILL || state == PH_UNC);
    tmr_tick = (state == PH_SETTLE) && !tmr_zero;
  end

  miss_seq_addr #(
    .AW(AW), .WW(WW), .DLINE_WORDS(DLINE_WORDS), .ILINE_WORDS(ILINE_WORDS)
  ) u_addr (
    .phase(nx_phase), .instr(cur_op.instr), .dword(cur_op.dword),
    .req_addr(cur_raddr), .victim_addr(cur_vaddr), .beat(nx_beat),
    .addr(nx_addr)
  );

  miss_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .tick(tmr_tick), .zero(tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PH_IDLE;
      op_r        <= '0;
      raddr_r     <= '0;
      vaddr_r     <= '0;
      unc_wdata_r <= '0;
      lo_wdata_r  <= '0;
      lo_be_r     <= '0;
      beat        <= '0;
      bus_req     <= 1'b0;
      bus_we      <= 1'b0;
      bus_addr    <= '0;
      bus_be      <= '0;
      lb_rd_idx   <= '0;
      lb_wr_en    <= 1'b0;
      lb_wr_idx   <= '0;
      lb_wr_data  <= '0;
      fetch_word  <= '0;
      load_data   <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      done     <= 1'b0;
      lb_wr_en <= 1'b0;
      unique case (state)
        PH_IDLE: if (start) begin
          state       <= first_ph;
          op_r        <= in_op;
          raddr_r     <= req_addr;
          vaddr_r     <= victim_addr;
          lo_wdata_r  <= st_wdata[WW-1:0];
          lo_be_r     <= st_wmask[BEW-1:0];
          unc_wdata_r <= in_op.dword ? st_wdata[2*WW-1:WW] : st_wdata[WW-1:0];
          bus_be      <= !in_op.write ? '1 :
                         (in_op.dword ? st_wmask[2*BEW-1:BEW] : st_wmask[BEW-1:0]);
          bus_we      <= (first_ph == PH_WBACK) || (first_ph == PH_UNC && in_op.write);
          bus_req     <= 1'b1;
          bus_addr    <= nx_addr;
          beat        <= '0;
          lb_rd_idx   <= XORV;
          load_data   <= '0;
          busy        <= 1'b1;
        end
        PH_WBACK: if (beat_done) begin
          beat      <= nx_beat;
          bus_addr  <= nx_addr;
          lb_rd_idx <= nx_beat ^ XORV;
          if (last_beat) begin
            state  <= PH_FILL;
            bus_we <= 1'b0;
            bus_be <= '1;
          end
        end
        PH_FILL: if (beat_done) begin
          lb_wr_en   <= 1'b1;
          lb_wr_idx  <= op_r.instr ? beat : (beat ^ XORV);
          lb_wr_data <= bus_rdata;
          if (op_r.instr && beat == raddr_r[IBO-1:WBO]) fetch_word <= bus_rdata;
          if (last_beat) begin
            state   <= PH_SETTLE;
            bus_req <= 1'b0;
          end else begin
            beat     <= nx_beat;
            bus_addr <= nx_addr;
          end
        end
        PH_UNC: if (beat_done) begin
          if (!op_r.write) begin
            if (op_r.instr)                  fetch_word <= bus_rdata;
            else if (op_r.dword && beat == '0) load_data[2*WW-1:WW] <= bus_rdata;
            else                             load_data[WW-1:0] <= bus_rdata;
          end
          if (last_beat) begin
            state   <= PH_SETTLE;
            bus_req <= 1'b0;
            bus_we  <= 1'b0;
          end else begin
            beat        <= nx_beat;
            bus_addr    <= nx_addr;
            unc_wdata_r <= lo_wdata_r;
            bus_be      <= op_r.write ? lo_be_r : '1;
          end
        end
        PH_SETTLE: if (tmr_zero) begin
          state <= PH_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  // R2
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_addr[WBO-1:0] == '0));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !bus_req));

  // R10
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

  // R6
  fill_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    lb_wr_en |-> (busy && !bus_we));

endmodule

// File: tb/miss_seq_tb.sv
module miss_seq_tb;
  localparam int UD = 2, DD = 3, ID = 5, XR = 1;

  typedef struct packed {
    logic        instr, cached, write, dword, dirty;
    logic [31:0] addr, vaddr;
    logic [63:0] wdata;
    logic [7:0]  wmask;
    logic [3:0]  gap;
    logic [3:0]  nbeats;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 32'h0000_1234, 32'h0000_5674, 64'h0, 8'h00, 4'd0, 4'd8},
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 32'h0000_2208, 32'h0000_0000, 64'h0, 8'h00, 4'd1, 4'd4},
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 32'h0000_3014, 32'h0000_0000, 64'h0, 8'h00, 4'd0, 4'd8},
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 32'h0000_401C, 32'h0000_0000, 64'h0, 8'h00, 4'd2, 4'd8},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 32'h0000_5006, 32'h0000_0000, 64'h0, 8'h00, 4'd0, 4'd2},
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_600A, 32'h0000_0000, 64'h0, 8'h00, 4'd1, 4'd1},
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0000_700C, 32'h0000_0000, 64'h1122334455667788, 8'hC3, 4'd0, 4'd2},
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 32'h0000_8002, 32'h0000_0000, 64'hCAFEBABEDEADBEEF, 8'hF6, 4'd0, 4'd1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 32'h0000_9006, 32'h0000_0000, 64'h0, 8'h00, 4'd3, 4'd1},
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 32'h0000_B0F8, 32'h0000_A03C, 64'h0, 8'h00, 4'd1, 4'd8}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, start, op_instr, op_cached, op_write, op_dword, victim_dirty;
  logic [31:0] req_addr, victim_addr;
  logic [63:0] st_wdata;
  logic [7:0]  st_wmask;
  logic        bus_req, bus_we, bus_ack;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;
  logic [2:0]  lb_rd_idx, lb_wr_idx;
  logic [31:0] lb_rd_data, lb_wr_data, fetch_word;
  logic        lb_wr_en, busy, done;
  logic [63:0] load_data;

  function automatic logic [31:0] vic_word(int i);
    return 32'hB000_0000 + 32'(i) * 32'h0101;
  endfunction
  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign lb_rd_data = vic_word(int'(lb_rd_idx));

  miss_seq #(.WORD_XOR(XR), .UNC_DELAY(UD), .DC_DELAY(DD), .IC_DELAY(ID)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_instr(op_instr), .op_cached(op_cached),
    .op_write(op_write), .op_dword(op_dword), .victim_dirty(victim_dirty),
    .req_addr(req_addr), .victim_addr(victim_addr), .st_wdata(st_wdata),
    .st_wmask(st_wmask), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .lb_rd_idx(lb_rd_idx), .lb_rd_data(lb_rd_data), .lb_wr_en(lb_wr_en),
    .lb_wr_idx(lb_wr_idx), .lb_wr_data(lb_wr_data), .fetch_word(fetch_word),
    .load_data(load_data), .busy(busy), .done(done)
  );

  int n_chk = 0, n_bad = 0;
  int g_gap = 0;
  int tr_n = 0, lw_n = 0;
  logic [31:0] tr_addr [16];
  logic        tr_we   [16];
  logic [31:0] tr_data [16];
  logic [3:0]  tr_be   [16];
  logic [2:0]  lw_idx  [16];
  logic [31:0] lw_data [16];

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic slave();
    int wc = 0;
    bus_ack = 1'b0;
    bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        bus_ack = 1'b0; wc = 0;
      end else if (bus_ack) begin
        bus_ack = 1'b0; wc = 0;
      end else if (bus_req) begin
        if (wc >= g_gap) begin
          bus_ack = 1'b1;
          bus_rdata = bus_we ? 32'h0 : mem_word(bus_addr);
          if (tr_n < 16) begin
            tr_addr[tr_n] = bus_addr; tr_we[tr_n] = bus_we;
            tr_data[tr_n] = bus_wdata; tr_be[tr_n] = bus_be;
          end
          tr_n++;
        end else wc++;
      end
      if (lb_wr_en) begin
        if (lw_n < 16) begin
          lw_idx[lw_n] = lb_wr_idx; lw_data[lw_n] = lb_wr_data;
        end
        lw_n++;
      end
    end
  endtask

  task automatic launch(vec_t v);
    tr_n = 0; lw_n = 0; g_gap = int'(v.gap);
    @(negedge clk);
    op_instr = v.instr; op_cached = v.cached; op_write = v.write;
    op_dword = v.dword; victim_dirty = v.dirty; req_addr = v.addr;
    victim_addr = v.vaddr; st_wdata = v.wdata; st_wmask = v.wmask;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc, output bit bad_busy);
    cyc = 0; bad_busy = 0;
    while (1) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (done) break;
      if (!busy) bad_busy = 1;
      if (cyc > 3000) break;
    end
  endtask

  function automatic string kind_tag(vec_t v);
    if (v.cached && v.instr) return "R7";
    if (v.cached && v.dirty) return "R5";
    if (v.cached)            return "R6";
    if (v.instr)             return "R8";
    if (v.write)             return "R4";
    return "R3";
  endfunction

  task automatic exp_beat(vec_t v, int j, output logic [31:0] a, output logic we,
                          output logic [31:0] d, output logic [3:0] be);
    int k = j;
    we = 0; d = '0; be = 4'hF;
    if (v.cached && !v.instr && v.dirty) begin
      if (j < 4) begin
        a = {v.vaddr[31:4], 4'h0} + 32'(4 * j);
        we = 1; d = vic_word(j ^ XR); be = 4'hF;
        return;
      end
      k = j - 4;
    end
    if (v.cached) begin
      a = (v.instr ? {v.addr[31:5], 5'h0} : {v.addr[31:4], 4'h0}) + 32'(4 * k);
    end else if (!v.instr && v.dword) begin
      a = {v.addr[31:3], 3'h0} + 32'(4 * j);
      we = v.write;
      d = (j == 0) ? v.wdata[63:32] : v.wdata[31:0];
      be = (j == 0) ? v.wmask[7:4] : v.wmask[3:0];
    end else begin
      a = {v.addr[31:2], 2'h0};
      we = v.write && !v.instr;
      d = v.wdata[31:0];
      be = v.wmask[3:0];
    end
  endtask

  task automatic run_vec(vec_t v);
    int cyc, d, expc, nfill;
    bit bb;
    string tg = kind_tag(v);
    logic [31:0] ea, ed, base;
    logic ew;
    logic [3:0] ebe;
    launch(v);
    wait_done(cyc, bb);
    d = !v.cached ? UD : (v.instr ? ID : DD);
    expc = 2 + int'(v.gap) + (int'(v.nbeats) - 1) * (int'(v.gap) + 2) + d;
    chk(cyc == expc, "R9", "cycles start to done", 64'(cyc), 64'(expc));
    chk(!bb && !busy, "R10", "busy through access", 64'(bb), 64'h0);
    chk(tr_n == int'(v.nbeats), "R2", {tg, " transfer count"}, 64'(tr_n), 64'(v.nbeats));
    for (int j = 0; j < int'(v.nbeats) && j < tr_n; j++) begin
      exp_beat(v, j, ea, ew, ed, ebe);
      chk(tr_addr[j] == ea && tr_we[j] == ew &&
          (!ew || (tr_data[j] == ed && tr_be[j] == ebe)),
          tg, $sformatf("beat %0d addr/we/data/be", j),
          {tr_addr[j], tr_data[j] ^ {28'h0, tr_be[j]}}, {ea, ed ^ {28'h0, ebe}});
    end
    if (v.cached) begin
      nfill = v.instr ? 8 : 4;
      base = v.instr ? {v.addr[31:5], 5'h0} : {v.addr[31:4], 4'h0};
      chk(lw_n == nfill, tg, "refill write count", 64'(lw_n), 64'(nfill));
      for (int i = 0; i < nfill && i < lw_n; i++) begin
        logic [2:0] ei = v.instr ? 3'(i) : 3'(i ^ XR);
        chk(lw_idx[i] == ei && lw_data[i] == mem_word(base + 32'(4 * i)), tg,
            $sformatf("refill %0d idx/data", i), {29'h0, lw_idx[i], lw_data[i]},
            {29'h0, ei, mem_word(base + 32'(4 * i))});
      end
      if (v.instr)
        chk(fetch_word == mem_word(base + {27'h0, v.addr[4:2], 2'b0}), "R7",
            "forwarded fetch word", 64'(fetch_word),
            64'(mem_word(base + {27'h0, v.addr[4:2], 2'b0})));
    end else begin
      chk(lw_n == 0, tg, "no refill on uncached", 64'(lw_n), 64'h0);
      if (v.instr) begin
        chk(fetch_word == mem_word({v.addr[31:2], 2'b0}), "R8", "uncached fetch word",
            64'(fetch_word), 64'(mem_word({v.addr[31:2], 2'b0})));
      end else if (!v.write) begin
        logic [63:0] el;
        el = v.dword ? {mem_word({v.addr[31:3], 3'h0}), mem_word({v.addr[31:3], 3'h4})}
                     : {32'h0, mem_word({v.addr[31:2], 2'b0})};
        chk(load_data == el, "R3", "uncached load result", load_data, el);
      end
    end
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    bit bb;
    vec_t dv;
    rst = 1'b1; start = 1'b0; op_instr = 0; op_cached = 0; op_write = 0; op_dword = 0;
    victim_dirty = 0; req_addr = '0; victim_addr = '0; st_wdata = '0; st_wmask = '0;
    fork slave(); join_none
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !bus_req && !lb_wr_en, "R1", "outputs in reset",
        {60'h0, busy, done, bus_req, lb_wr_en}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !bus_req && !lb_wr_en, "R1", "outputs after reset",
        {60'h0, busy, done, bus_req, lb_wr_en}, 64'h0);

    for (int i = 0; i < 10; i++) run_vec(VECS[i]);

    // R10: start pulsed while busy must not launch anything
    dv = VECS[5];
    dv.gap = 4'd3;
    launch(dv);
    repeat (2) @(negedge clk);
    op_write = 1'b1; op_dword = 1'b1; req_addr = 32'h0000_F000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc, bb);
    chk(tr_n == 1 && tr_addr[0] == 32'h0000_6008 && !tr_we[0], "R10",
        "ignored start during access", {31'h0, tr_we[0], tr_addr[0]}, 64'h6008);
    repeat (4) @(negedge clk);
    chk(!busy && !bus_req && tr_n == 1, "R10", "no second access launched",
        64'(tr_n), 64'h1);

    // R1: reset in the middle of an access
    launch(VECS[3]);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_req && !done, "R1", "mid-access reset clears",
        {61'h0, busy, bus_req, done}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    run_vec(VECS[4]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule